// File: doc/BRIEF.md
# Binary FSK Tone Transmitter

This block converts bytes into a two-tone frequency-shift-keyed waveform and streams every waveform sample to an external 12-bit serial DAC. A byte is taken through a valid/ready handshake. It is then sent as one start bit of value 0 and eight data bits, least significant bit first. Each bit holds its tone for a fixed number of timer ticks. When no frame is in progress the line carries a 1, the mark tone.

Both tones read the same 20-entry table that holds one sine period. Only the number of ticks between two table reads differs: a short spacing gives the mark tone and a long spacing gives the space tone. The table index never resets, so the phase stays continuous when the tone changes. Each sample is framed as a 16-bit word and shifted out MSB first on an SPI-style link. SCK runs at half the system clock and chip select is held low for the whole word.

Top module: `fsk_tx`

## Requirements
- R1: While in reset and on the first cycle after it, cs_no is 1, sck_o is 0, mosi_o is 0 and ready_o is 1.
- R2: With no frame in progress, one DAC word starts every MARK_TICKS ticks, which is the mark tone for a 1.
- R3: During a 0 bit, words start SPACE_TICKS ticks apart, which is the space tone.
- R4: Each word has two fields. Bits 15:12 hold the command code 0011. Bits 11:0 hold the current table sample. The table index advances by one per word, wraps from 19 to 0, and keeps running across bit and frame boundaries.
- R5: Each word is shifted MSB first. cs_no stays low for exactly 16 SCK rising edges. SCK toggles every system clock. MOSI changes only when SCK falls, never when it rises.
- R6: An accepted byte is sent as a start bit 0 and then data bits 0 to 7. Each bit lasts BIT_TICKS ticks, counted from the acceptance cycle.
- R7: ready_o drops in the cycle after a byte is accepted and stays low until the last data bit ends. A byte offered while ready_o is low is held off and not taken.
- R8: One tick comes every TICK_DIV system clocks. The bit timer and the sample-interval timer both count this same tick.
- R9: The sine table holds these values in order from index 0: 2680, 3251, 3704, 3995, 4095, 3995, 3704, 3251, 2680, 2048, 1415, 844, 391, 100, 0, 100, 391, 844, 1415, 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Byte to send |
| valid_i | input | 1 | byte_i is offered |
| ready_o | output | 1 | A new byte can be accepted |
| sck_o | output | 1 | Serial clock to the DAC |
| mosi_o | output | 1 | Serial data to the DAC |
| cs_no | output | 1 | DAC chip select, active low |

## Verification
The bench builds the block with TICK_DIV=2, MARK_TICKS=20, SPACE_TICKS=60 and BIT_TICKS=240. This shrinks a frame to a few thousand clocks while keeping a 40-clock gap between words, which is longer than the 32-clock shift. The bench therefore sees many whole frames: mark-only and space-only bytes, tone switches partway through an interval, and several wraps of the table index. A tick divider above one shows that bit timing and sample timing both follow the shared tick, and a byte offered during a frame exercises the hold-off.

// File: rtl/fsk_tx_pkg.sv
package fsk_tx_pkg;
  localparam int unsigned SINE_LEN    = 20;
  localparam int unsigned SAMPLE_W    = 12;
  localparam int unsigned WORD_W      = 16;
  localparam logic [3:0]  DAC_CMD     = 4'b0011;
  localparam int unsigned IDX_W       = $clog2(SINE_LEN);

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [IDX_W-1:0]    sine_idx_t;

  function automatic sample_t sine_lookup(sine_idx_t idx);
    case (idx)
      5'd0:    return 12'd2680;
      5'd1:    return 12'd3251;
      5'd2:    return 12'd3704;
      5'd3:    return 12'd3995;
      5'd4:    return 12'd4095;
      5'd5:    return 12'd3995;
      5'd6:    return 12'd3704;
      5'd7:    return 12'd3251;
      5'd8:    return 12'd2680;
      5'd9:    return 12'd2048;
      5'd10:   return 12'd1415;
      5'd11:   return 12'd844;
      5'd12:   return 12'd391;
      5'd13:   return 12'd100;
      5'd14:   return 12'd0;
      5'd15:   return 12'd100;
      5'd16:   return 12'd391;
      5'd17:   return 12'd844;
      5'd18:   return 12'd1415;
      default: return 12'd2048;
    endcase
  endfunction
endpackage

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           cnt_q <= '0;
        else if (cnt_q == CW'(TICK_DIV - 1))   cnt_q <= '0;
        else                                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/fsk_framer.sv
module fsk_framer #(
  parameter int unsigned BIT_TICKS = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       line_bit_o
);
  localparam int unsigned TW = $clog2(BIT_TICKS + 1);

  logic          busy_q;
  logic [3:0]    bit_no_q;   // 0 = start bit, 1..8 = data bits
  logic [TW-1:0] bit_tmr_q;
  logic [7:0]    data_q;
  logic          accept;

  assign ready_o = !busy_q;
  assign accept  = valid_i && !busy_q;

  always_comb begin
    if (!busy_q)              line_bit_o = 1'b1;
    else if (bit_no_q == 4'd0) line_bit_o = 1'b0;
    else                      line_bit_o = data_q[3'(bit_no_q - 4'd1)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      bit_no_q  <= '0;
      bit_tmr_q <= '0;
      data_q    <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      bit_no_q  <= '0;
      bit_tmr_q <= '0;
      data_q    <= byte_i;
    end else if (busy_q && tick_i) begin
      if (bit_tmr_q == TW'(BIT_TICKS - 1)) begin
        bit_tmr_q <= '0;
        if (bit_no_q == 4'd8) busy_q   <= 1'b0;
        else                  bit_no_q <= bit_no_q + 4'd1;
      end else begin
        bit_tmr_q <= bit_tmr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_tone_stepper.sv
module fsk_tone_stepper
  import fsk_tx_pkg::*;
#(
  parameter int unsigned MARK_TICKS  = 83,
  parameter int unsigned SPACE_TICKS = 250
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    line_bit_i,
  output logic    fire_o,
  output sample_t sample_o
);
  localparam int unsigned MAXT = (MARK_TICKS > SPACE_TICKS) ? MARK_TICKS : SPACE_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] itv_q;
  logic [CW-1:0] limit;
  sine_idx_t     idx_q;

  assign limit    = line_bit_i ? CW'(MARK_TICKS - 1) : CW'(SPACE_TICKS - 1);
  // >= lets a switch to the shorter spacing fire at once
  assign fire_o   = tick_i && (itv_q >= limit);
  assign sample_o = sine_lookup(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      itv_q <= '0;
      idx_q <= '0;
    end else if (fire_o) begin
      itv_q <= '0;
      idx_q <= (idx_q == IDX_W'(SINE_LEN - 1)) ? '0 : idx_q + 1'b1;
    end else if (tick_i) begin
      itv_q <= itv_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_dac_shifter.sv
module fsk_dac_shifter
  import fsk_tx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  sample_t sample_i,
  output logic    sck_o,
  output logic    mosi_o,
  output logic    cs_no
);
  localparam int unsigned HW = $clog2(2 * WORD_W);

  logic              busy_q;
  logic [HW-1:0]     half_q;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= '0;
      sh_q   <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      half_q <= '0;
      sh_q   <= {DAC_CMD, sample_i};
    end else if (busy_q) begin
      if (half_q == HW'(2 * WORD_W - 1)) busy_q <= 1'b0;
      else                               half_q <= half_q + 1'b1;
      if (half_q[0]) sh_q <= {sh_q[WORD_W-2:0], 1'b0};  // shift as SCK falls
    end
  end

  assign cs_no  = !busy_q;
  assign sck_o  = busy_q && half_q[0];
  assign mosi_o = busy_q && sh_q[WORD_W-1];
endmodule

// File: rtl/fsk_tx.sv
module fsk_tx
  import fsk_tx_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 1,
  parameter int unsigned MARK_TICKS  = 83,
  parameter int unsigned SPACE_TICKS = 250,
  parameter int unsigned BIT_TICKS   = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       cs_no
);
  logic    tick;
  logic    line_bit;
  logic    fire;
  sample_t sample;

  fsk_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  fsk_framer #(.BIT_TICKS(BIT_TICKS)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .byte_i(byte_i),
    .valid_i(valid_i), .ready_o(ready_o), .line_bit_o(line_bit)
  );

  fsk_tone_stepper #(.MARK_TICKS(MARK_TICKS), .SPACE_TICKS(SPACE_TICKS)) u_tone (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_bit_i(line_bit),
    .fire_o(fire), .sample_o(sample)
  );

  fsk_dac_shifter u_dac (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fire), .sample_i(sample),
    .sck_o(sck_o), .mosi_o(mosi_o), .cs_no(cs_no)
  );
endmodule

// File: rtl/fsk_tx_checker.sv
module fsk_tx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic sck_o,
  input logic mosi_o,
  input logic cs_no,
  input logic line_bit,
  input logic fire
);
  logic       sck_prev_q;
  logic [4:0] rises_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      rises_q    <= '0;
    end else begin
      sck_prev_q <= sck_o;
      if (cs_no)                    rises_q <= '0;
      else if (sck_o && !sck_prev_q) rises_q <= rises_q + 1'b1;
    end
  end

  assert_sixteen_edges_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> rises_q == 5'd16);
  assert_sck_in_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  assert_sck_half_rate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);
  assert_mosi_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));
  assert_no_overrun_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> cs_no);
  assert_cmd_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !mosi_o);
  assert_idle_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> line_bit);
  assert_hold_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
endmodule

bind fsk_tx fsk_tx_checker u_fsk_tx_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .sck_o(sck_o), .mosi_o(mosi_o), .cs_no(cs_no), .line_bit(line_bit), .fire(fire)
);

// File: tb/tb_fsk_tx.sv
module tb_fsk_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int MARK  = 20;
  localparam int SPACE = 60;
  localparam int BITT  = 240;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       valid_i = 1'b0;
  logic       ready_o, sck_o, mosi_o, cs_no;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fsk_tx #(.TICK_DIV(DIV), .MARK_TICKS(MARK), .SPACE_TICKS(SPACE), .BIT_TICKS(BITT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(valid_i),
    .ready_o(ready_o), .sck_o(sck_o), .mosi_o(mosi_o), .cs_no(cs_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int tab [20] = '{2680, 3251, 3704, 3995, 4095, 3995, 3704, 3251, 2680, 2048,
                   1415, 844, 391, 100, 0, 100, 391, 844, 1415, 2048};

  // behavioural reference state
  int m_tc, m_fbusy, m_bitno, m_btmr, m_data, m_itv, m_idx, m_sbusy, m_scnt, m_word;
  int accepted;
  // port-side decoder state
  int cyc, last_fall, word_in, bits_in, exp_idx, prev_sck, prev_cs;
  int n_mark_itv, n_space_itv, n_words;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_tc = 0; m_fbusy = 0; m_bitno = 0; m_btmr = 0; m_data = 0;
    m_itv = 0; m_idx = 0; m_sbusy = 0; m_scnt = 0; m_word = 0;
  endtask

  // advance the reference by the posedge just passed, then compare and decode
  task automatic step();
    int tk, line, acc, lim, fire;
    tk   = (m_tc == DIV - 1);
    line = !m_fbusy ? 1 : (m_bitno == 0 ? 0 : (m_data >> (m_bitno - 1)) & 1);
    acc  = valid_i && !m_fbusy;
    lim  = line ? MARK : SPACE;
    fire = tk && (m_itv >= lim - 1);
    m_tc = tk ? 0 : m_tc + 1;
    if (acc) begin
      m_fbusy = 1; m_bitno = 0; m_btmr = 0; m_data = byte_i;
    end else if (m_fbusy && tk) begin
      if (m_btmr == BITT - 1) begin
        m_btmr = 0;
        if (m_bitno == 8) m_fbusy = 0; else m_bitno++;
      end else m_btmr++;
    end
    if (fire && !m_sbusy) begin
      m_sbusy = 1; m_scnt = 0; m_word = 'h3000 | tab[m_idx];
    end else if (m_sbusy) begin
      if (m_scnt % 2 == 1) m_word = (m_word << 1) & 'hFFFF;
      if (m_scnt == 31) m_sbusy = 0; else m_scnt++;
    end
    if (fire) begin m_itv = 0; m_idx = (m_idx + 1) % 20; end
    else if (tk) m_itv++;
    accepted = acc;
    cyc++;
    // per-clock comparison covers timing of R2 R3 R6 R8
    check(cs_no == !m_sbusy, "R2 R3 R6 R8 cs_no", cs_no, !m_sbusy);
    check(sck_o == (m_sbusy && (m_scnt % 2 == 1)), "R5 R8 sck_o", sck_o, m_sbusy && (m_scnt % 2 == 1));
    check(mosi_o == (m_sbusy ? (m_word >> 15) & 1 : 0), "R5 R6 mosi_o", mosi_o, m_sbusy ? (m_word >> 15) & 1 : 0);
    check(ready_o == !m_fbusy, "R7 ready_o", ready_o, !m_fbusy);
    // decode words at the ports
    if (prev_cs && !cs_no) begin
      if (last_fall >= 0) begin
        if (cyc - last_fall == MARK * DIV) n_mark_itv++;
        if (cyc - last_fall == SPACE * DIV) n_space_itv++;
      end
      last_fall = cyc; word_in = 0; bits_in = 0;
    end
    if (!cs_no && sck_o && !prev_sck) begin
      word_in = (word_in << 1) | mosi_o; bits_in++;
    end
    if (!prev_cs && cs_no) begin
      check(bits_in == 16, "R5 bits per word", bits_in, 16);
      check((word_in >> 12) == 3, "R4 command nibble", word_in >> 12, 3);
      check((word_in & 'hFFF) == tab[exp_idx], "R4 R9 sample", word_in & 'hFFF, tab[exp_idx]);
      exp_idx = (exp_idx + 1) % 20;
      n_words++;
    end
    prev_cs = cs_no; prev_sck = sck_o;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_i); step(); end
  endtask

  task automatic send(input logic [7:0] b, output int wait_cyc);
    valid_i = 1'b1; byte_i = b; wait_cyc = 0;
    do begin @(negedge clk_i); step(); wait_cyc++; end while (!accepted);
    valid_i = 1'b0;
  endtask

  initial begin
    int w, sp0, mk0;
    cyc = 0; last_fall = -1; exp_idx = 0; prev_cs = 1; prev_sck = 0;
    n_mark_itv = 0; n_space_itv = 0; n_words = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    check(cs_no && !sck_o && !mosi_o && ready_o, "R1 reset outputs", {cs_no, sck_o, mosi_o, ready_o}, 4'b1001);
    rst_ni = 1'b1;
    @(negedge clk_i); step();
    check(cs_no && !sck_o && ready_o, "R1 first cycle", {cs_no, sck_o, ready_o}, 3'b101);
    run(400);
    check(n_mark_itv >= 8 && n_space_itv == 0, "R2 idle mark spacing", n_mark_itv, 9);
    // mixed byte, then a byte offered during the frame
    send(8'hA5, w);
    check(w == 1, "R7 accept when ready", w, 1);
    send(8'h3C, w);
    check(w >= 9 * BITT * DIV - 2, "R7 hold-off length", w, 9 * BITT * DIV);
    run(9 * BITT * DIV + 200);
    sp0 = n_space_itv;
    send(8'h00, w);
    run(9 * BITT * DIV);
    check(n_space_itv - sp0 >= 30, "R3 R6 space spacing in zero byte", n_space_itv - sp0, 35);
    run(100);
    sp0 = n_space_itv; mk0 = n_mark_itv;
    send(8'hFF, w);
    run(9 * BITT * DIV);
    check(n_space_itv - sp0 >= 2 && n_space_itv - sp0 <= 5, "R6 start bit only space", n_space_itv - sp0, 4);
    check(n_mark_itv - mk0 >= 90, "R2 R6 mark data bits", n_mark_itv - mk0, 96);
    run(200);
    check(n_words > 40 && exp_idx != 0 || n_words % 20 == 0, "R4 index wrap", n_words, 41);
    check(ready_o == 1, "R7 idle after frame", ready_o, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule